// File: doc/BRIEF.md
# Delayed Power-Domain Sequencer

This block lets firmware steer the supply state and voltage code of several power domains through a small register bus, with every change held back for a programmable number of clock cycles before it reaches the domain. A write names a domain and the wanted state or voltage code. The block files it as that domain's pending request, counts down a delay, and then drives the new value on the domain's output pins.

The hold time of a state change is picked by the direction of the move. Each domain has its own delay word for each direction. All voltage changes share one delay register. A capture counter can be started and stopped through the bus. While it runs, it adds up the number of domains that sit in the fully-on state on every cycle, so firmware can read back an activity figure for the interval.

Top module: `pdc_top`

## Requirements
- R1: After reset every domain output reads OFF (0) with voltage code 0. Every delay register, the voltage delay register and the capture value read 0.
- R2: The bus address is {window[2:0], offset}. Windows: 0 = state request, 1 = voltage request, 2 = capture control, 3 = state delay words, 4 = voltage delay. A state write takes bit 0 = powered and bit 1 = clock running: 3 gives ON, 1 gives ON_CLOCK_GATED, and any value with bit 0 clear gives OFF. The domain state outputs are encoded OFF=0, ON=1, ON_CLOCK_GATED=2.
- R3: Domain d owns the delay words at offset 4·d+k in window 3. The slots are k=0 on→off, k=1 off→on, k=2 on→gated and k=3 gated→on. A state write accepted at clock edge t shows on the outputs from edge t+D+1, where D is the selected delay.
- R4: Moving from off to gated uses the off→on slot, and moving from gated to off uses the on→off slot.
- R5: A state write equal to the domain's current output state is ignored. It starts no timer and sets no pending flag.
- R6: A voltage write (window 1, offset = domain) accepted at edge t shows on that domain's voltage output from edge t+V+1, where V is the voltage delay register.
- R7: A new state or voltage request for a domain that still has a change pending discards the older request and restarts the countdown. The older request is never applied.
- R8: A read of the state window returns the domain's current state code in bits [1:0] and its pending flag in bit 31.
- R9: Writing the capture window with bit 0 = 1 clears the count and starts a capture. Writing it with bit 0 = 0 stops the capture. While running, the count grows on every edge by the number of domains in ON, up to and including the stop edge. It holds its value once stopped.
- R10: The capture count saturates at all ones and does not wrap.
- R11: Read data is valid on busRdData, with busRdValid high, for the single cycle after the edge that samples busRdEn. The delay words and the voltage delay read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | OFS_W+3 | Word address {window, offset} |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data |
| busRdValid | output | 1 | Read data valid |
| domState | output | 2·N_DOM | Per-domain state code, domain d at [2d+1:2d] |
| domVolt | output | VOLT_W·N_DOM | Per-domain voltage code |

## Verification
Each state or voltage change is due exactly D+1 edges after the edge that accepts the write. The bench therefore samples the domain outputs on the falling edge just before that point, where the old value must remain, and on the falling edge just after, where the new value must appear. Read results arrive one edge after the request. A scoreboard queue holds the expected word, and a monitor compares it on the falling edge where busRdValid is high. Capture values are predicted by counting the edges from the start write to the stop write inclusive, multiplied by the number of fully-on domains, which the bench keeps constant over each capture.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_ON    = 2'd1,
    PS_GATED = 2'd2
  } pwr_state_e;

  localparam logic [2:0] WIN_STATE  = 3'd0;
  localparam logic [2:0] WIN_VOLT   = 3'd1;
  localparam logic [2:0] WIN_CAP    = 3'd2;
  localparam logic [2:0] WIN_STDLY  = 3'd3;
  localparam logic [2:0] WIN_VDLY   = 3'd4;

  // delay slot index within a domain group
  localparam int SLOT_ON_OFF    = 0;
  localparam int SLOT_OFF_ON    = 1;
  localparam int SLOT_ON_GATED  = 2;
  localparam int SLOT_GATED_ON  = 3;
  localparam int SLOTS_PER_DOM  = 4;

  typedef struct packed {
    logic       stateWr;
    logic       voltWr;
    logic       capWr;
    logic       stDlyWr;
    logic       vDlyWr;
    logic       rdStb;
    logic [2:0] rdWin;
  } ctrl_strobe_t;

endpackage

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int N_DOM = 4,
  parameter int OFS_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [OFS_W+2:0]   busAddr,
  output ctrl_strobe_t       strb,
  output logic               busRdValid
);

  localparam logic [31:0] DOM_LIM = 32'(N_DOM);
  localparam logic [31:0] DLY_LIM = 32'(SLOTS_PER_DOM * N_DOM);

  logic [2:0]       win;
  logic [OFS_W-1:0] ofs;
  logic             domOk;
  logic             dlyOk;

  assign win   = busAddr[OFS_W+2:OFS_W];
  assign ofs   = busAddr[OFS_W-1:0];
  assign domOk = 32'(ofs) < DOM_LIM;
  assign dlyOk = 32'(ofs) < DLY_LIM;

  always_comb begin
    strb         = '0;
    strb.stateWr = busWrEn && (win == WIN_STATE) && domOk;
    strb.voltWr  = busWrEn && (win == WIN_VOLT)  && domOk;
    strb.capWr   = busWrEn && (win == WIN_CAP);
    strb.stDlyWr = busWrEn && (win == WIN_STDLY) && dlyOk;
    strb.vDlyWr  = busWrEn && (win == WIN_VDLY);
    strb.rdStb   = busRdEn;
    strb.rdWin   = win;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdValid <= 1'b0;
    else       busRdValid <= busRdEn;
  end

  // R11: read answer comes exactly one cycle after the request
  a_r11_rd_latency: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid);
  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid);

endmodule

// File: rtl/pdc_domain.sv
module pdc_domain
  import pdc_pkg::*;
#(
  parameter int VOLT_W = 8,
  parameter int DLY_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stReq,
  input  logic [1:0]              stCode,
  input  logic                    vReq,
  input  logic [VOLT_W-1:0]       vCode,
  input  logic [3:0][DLY_W-1:0]   dlyCfg,
  input  logic [DLY_W-1:0]        vDelay,
  output pwr_state_e              curState,
  output logic [VOLT_W-1:0]       curVolt,
  output logic                    pending
);

  pwr_state_e        reqState;
  pwr_state_e        tgtState;
  logic [VOLT_W-1:0] tgtVolt;
  logic              tgtIsVolt;
  logic [DLY_W-1:0]  timer;
  logic [DLY_W-1:0]  stDelay;
  logic              stChange;

  always_comb begin
    if (!stCode[0])     reqState = PS_OFF;
    else if (stCode[1]) reqState = PS_ON;
    else                reqState = PS_GATED;
  end

  // direction of move picks the delay slot
  always_comb begin
    stDelay = dlyCfg[SLOT_ON_OFF];
    unique case ({curState, reqState})
      {PS_ON,    PS_OFF}:   stDelay = dlyCfg[SLOT_ON_OFF];
      {PS_OFF,   PS_ON}:    stDelay = dlyCfg[SLOT_OFF_ON];
      {PS_ON,    PS_GATED}: stDelay = dlyCfg[SLOT_ON_GATED];
      {PS_GATED, PS_ON}:    stDelay = dlyCfg[SLOT_GATED_ON];
      {PS_OFF,   PS_GATED}: stDelay = dlyCfg[SLOT_OFF_ON];
      {PS_GATED, PS_OFF}:   stDelay = dlyCfg[SLOT_ON_OFF];
      default:              stDelay = dlyCfg[SLOT_ON_OFF];
    endcase
  end

  assign stChange = stReq && (reqState != curState);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState  <= PS_OFF;
      curVolt   <= '0;
      tgtState  <= PS_OFF;
      tgtVolt   <= '0;
      tgtIsVolt <= 1'b0;
      timer     <= '0;
      pending   <= 1'b0;
    end else if (stChange) begin
      pending   <= 1'b1;
      tgtIsVolt <= 1'b0;
      tgtState  <= reqState;
      timer     <= stDelay;
    end else if (vReq) begin
      pending   <= 1'b1;
      tgtIsVolt <= 1'b1;
      tgtVolt   <= vCode;
      timer     <= vDelay;
    end else if (pending) begin
      if (timer == '0) begin
        pending <= 1'b0;
        if (tgtIsVolt) curVolt  <= tgtVolt;
        else           curState <= tgtState;
      end else begin
        timer <= timer - 1'b1;
      end
    end
  end

  // R3: outputs move only when a pending request has run its timer out
  a_r3_apply_after_timeout: assert property (@(posedge clk) disable iff (!rstN)
    (curState != $past(curState)) |-> $past(pending && timer == '0));
  a_r6_volt_after_timeout: assert property (@(posedge clk) disable iff (!rstN)
    (curVolt != $past(curVolt)) |-> $past(pending && timer == '0 && tgtIsVolt));
  // R2: the unused code 3 never reaches a domain
  a_r2_legal_state: assert property (@(posedge clk) disable iff (!rstN)
    curState != 2'd3);
  // R7: an expired request with nothing new behind it leaves the pending state
  a_r7_pend_drains: assert property (@(posedge clk) disable iff (!rstN)
    (pending && timer == '0 && !stChange && !vReq) |=> !pending);

endmodule

// File: rtl/pdc_datapath.sv
module pdc_datapath
  import pdc_pkg::*;
#(
  parameter int N_DOM  = 4,
  parameter int VOLT_W = 8,
  parameter int DLY_W  = 16,
  parameter int CNT_W  = 32,
  parameter int OFS_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobe_t              strb,
  input  logic [OFS_W-1:0]          ofs,
  input  logic [31:0]               wrData,
  output logic [31:0]               rdData,
  output logic [2*N_DOM-1:0]        domState,
  output logic [VOLT_W*N_DOM-1:0]   domVolt
);

  localparam int N_SLOT = SLOTS_PER_DOM * N_DOM;
  localparam int INC_W  = $clog2(N_DOM + 1);

  logic [DLY_W-1:0]  dlyReg [N_SLOT];
  logic [DLY_W-1:0]  vDelay;
  logic [CNT_W-1:0]  capCnt;
  logic              capRun;
  logic              capStart;
  logic [INC_W-1:0]  onCount;
  logic [CNT_W:0]    capSum;

  pwr_state_e        stArr   [N_DOM];
  logic [VOLT_W-1:0] voltArr [N_DOM];
  logic [N_DOM-1:0]  pendVec;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_SLOT; i++) dlyReg[i] <= '0;
      vDelay <= '0;
    end else begin
      if (strb.stDlyWr) dlyReg[ofs] <= wrData[DLY_W-1:0];
      if (strb.vDlyWr)  vDelay      <= wrData[DLY_W-1:0];
    end
  end

  // per-domain sequencers
  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic [3:0][DLY_W-1:0] cfg;
    logic                  hit;
    for (genvar k = 0; k < SLOTS_PER_DOM; k++) begin : g_cfg
      assign cfg[k] = dlyReg[SLOTS_PER_DOM*d + k];
    end
    assign hit = (32'(ofs) == 32'(d));

    pdc_domain #(.VOLT_W(VOLT_W), .DLY_W(DLY_W)) u_dom (
      .clk      (clk),
      .rstN     (rstN),
      .stReq    (strb.stateWr && hit),
      .stCode   (wrData[1:0]),
      .vReq     (strb.voltWr && hit),
      .vCode    (wrData[VOLT_W-1:0]),
      .dlyCfg   (cfg),
      .vDelay   (vDelay),
      .curState (stArr[d]),
      .curVolt  (voltArr[d]),
      .pending  (pendVec[d])
    );

    assign domState[2*d +: 2]       = stArr[d];
    assign domVolt[VOLT_W*d +: VOLT_W] = voltArr[d];
  end

  // activity capture
  always_comb begin
    onCount = '0;
    for (int d = 0; d < N_DOM; d++)
      if (stArr[d] == PS_ON) onCount = onCount + 1'b1;
  end

  assign capStart = strb.capWr && wrData[0];
  assign capSum   = {1'b0, capCnt} + (CNT_W+1)'(onCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capRun <= 1'b0;
      capCnt <= '0;
    end else if (capStart) begin
      capRun <= 1'b1;
      capCnt <= '0;
    end else begin
      if (capRun) capCnt <= capSum[CNT_W] ? '1 : capSum[CNT_W-1:0];
      if (strb.capWr) capRun <= 1'b0;
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdStb) begin
      rdData <= '0;
      unique case (strb.rdWin)
        WIN_STATE: begin
          for (int d = 0; d < N_DOM; d++)
            if (32'(ofs) == 32'(d)) rdData <= {pendVec[d], 29'd0, stArr[d]};
        end
        WIN_VOLT: begin
          for (int d = 0; d < N_DOM; d++)
            if (32'(ofs) == 32'(d)) rdData <= 32'(voltArr[d]);
        end
        WIN_CAP:   rdData <= 32'(capCnt);
        WIN_STDLY: begin
          if (32'(ofs) < 32'(N_SLOT)) rdData <= 32'(dlyReg[ofs]);
        end
        WIN_VDLY:  rdData <= 32'(vDelay);
        default:   rdData <= '0;
      endcase
    end
  end

  // R9: a stopped capture keeps its value
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!capRun && !capStart) |=> $stable(capCnt));
  // R10: the count sticks at its maximum
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (capCnt == '1 && !capStart) |=> capCnt == '1);
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    capStart |=> (capCnt == '0 && capRun));

endmodule

// File: rtl/pdc_top.sv
module pdc_top
  import pdc_pkg::*;
#(
  parameter int N_DOM  = 4,
  parameter int VOLT_W = 8,
  parameter int DLY_W  = 16,
  parameter int CNT_W  = 32,
  localparam int OFS_W = $clog2(SLOTS_PER_DOM * N_DOM),
  localparam int ADDR_W = OFS_W + 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [31:0]              busWrData,
  output logic [31:0]              busRdData,
  output logic                     busRdValid,
  output logic [2*N_DOM-1:0]       domState,
  output logic [VOLT_W*N_DOM-1:0]  domVolt
);

  ctrl_strobe_t strb;

  pdc_ctrl #(.N_DOM(N_DOM), .OFS_W(OFS_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .strb       (strb),
    .busRdValid (busRdValid)
  );

  pdc_datapath #(
    .N_DOM(N_DOM), .VOLT_W(VOLT_W), .DLY_W(DLY_W), .CNT_W(CNT_W), .OFS_W(OFS_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ofs      (busAddr[OFS_W-1:0]),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .domState (domState),
    .domVolt  (domVolt)
  );

endmodule

// File: tb/pdc_top_bench.sv
module pdc_top_bench;

  localparam int N_DOM  = 4;
  localparam int VOLT_W = 8;
  localparam int OFS_W  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [OFS_W+2:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic [2*N_DOM-1:0]      domState;
  logic [VOLT_W*N_DOM-1:0] domVolt;
  logic [31:0] satRdData;
  logic        satRdValid;
  logic [2*N_DOM-1:0]      satState;
  logic [VOLT_W*N_DOM-1:0] satVolt;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  pdc_top u_pdc_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .domState(domState), .domVolt(domVolt)
  );

  // narrow-counter copy for the saturation case, fed the same bus
  pdc_top #(.CNT_W(6)) u_pdc_top_sat (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(satRdData),
    .busRdValid(satRdValid), .domState(satState), .domVolt(satVolt)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] win, input int ofs, input logic [31:0] d);
    busAddr   = {win, OFS_W'(ofs)};
    busWrData = d;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  // driver: pushes the expected word, the monitor compares it
  task automatic busRead(input logic [2:0] win, input int ofs, input logic [31:0] exp,
                         input string tag);
    busAddr = {win, OFS_W'(ofs)};
    busRdEn = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  function automatic logic [1:0] stOf(input int d);
    return domState[2*d +: 2];
  endfunction

  function automatic logic [7:0] vOf(input int d);
    return domVolt[VOLT_W*d +: VOLT_W];
  endfunction

  // old value holds through D falling edges, new value one edge later
  task automatic expectState(input int d, input int dly, input logic [1:0] oldS,
                             input logic [1:0] newS, input string tag);
    repeat (dly) @(negedge clk);
    check(32'(stOf(d)), 32'(oldS), {tag, " before delay"});
    @(negedge clk);
    check(32'(stOf(d)), 32'(newS), {tag, " after delay"});
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R11 unexpected read valid actual=0x%0h expected=none", busRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(busRdData, e, t);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    check(32'(domState), 32'd0, "R1 states off");
    check(32'(domVolt), 32'd0, "R1 voltages zero");
    busRead(3'd0, 0, 32'd0, "R1 state read d0");
    busRead(3'd3, 5, 32'd0, "R1 delay word");
    busRead(3'd4, 0, 32'd0, "R1 voltage delay");
    busRead(3'd2, 0, 32'd0, "R1 capture value");

    // R3 delay words for domain 0
    busWrite(3'd3, 0, 32'd6);
    busWrite(3'd3, 1, 32'd3);
    busWrite(3'd3, 2, 32'd4);
    busWrite(3'd3, 3, 32'd2);
    busRead(3'd3, 1, 32'd3, "R11 delay readback");
    busRead(3'd3, 2, 32'd4, "R11 delay readback slot2");

    // R2 / R3 each direction
    busWrite(3'd0, 0, 32'd3);
    expectState(0, 3, 2'd0, 2'd1, "R3 off->on");
    busWrite(3'd0, 0, 32'd1);
    expectState(0, 4, 2'd1, 2'd2, "R3 on->gated");
    busWrite(3'd0, 0, 32'd3);
    expectState(0, 2, 2'd2, 2'd1, "R3 gated->on");
    busWrite(3'd0, 0, 32'd0);
    expectState(0, 6, 2'd1, 2'd0, "R3 on->off");

    // R4 off<->gated borrow delays; R2 bit1 alone means off
    busWrite(3'd0, 0, 32'd1);
    expectState(0, 3, 2'd0, 2'd2, "R4 off->gated");
    busWrite(3'd0, 0, 32'd2);
    expectState(0, 6, 2'd2, 2'd0, "R4 gated->off via code 2 (R2)");

    // R5 same-state writes
    busWrite(3'd0, 0, 32'd0);
    busRead(3'd0, 0, 32'd0, "R5 no pending after same state");
    busWrite(3'd0, 0, 32'd2);
    busRead(3'd0, 0, 32'd0, "R5 code 2 on off domain ignored");
    repeat (8) @(negedge clk);
    check(32'(stOf(0)), 32'd0, "R5 state unchanged");

    // R3 zero delay on domain 1
    busWrite(3'd0, 1, 32'd3);
    expectState(1, 0, 2'd0, 2'd1, "R3 zero delay d1");

    // R6 voltage delay
    busWrite(3'd4, 0, 32'd5);
    busWrite(3'd1, 2, 32'h5A);
    repeat (5) @(negedge clk);
    check(32'(vOf(2)), 32'd0, "R6 voltage before delay");
    @(negedge clk);
    check(32'(vOf(2)), 32'h5A, "R6 voltage after delay");
    busRead(3'd1, 2, 32'h5A, "R6 voltage readback");

    // R8 pending flag
    busWrite(3'd4, 0, 32'd10);
    busWrite(3'd1, 3, 32'h33);
    busRead(3'd0, 3, 32'h8000_0000, "R8 pending set");
    repeat (15) @(negedge clk);
    check(32'(vOf(3)), 32'h33, "R8 voltage applied");
    busRead(3'd0, 3, 32'd0, "R8 pending clear");

    // R7 newer request replaces older
    busWrite(3'd3, 1, 32'd10);
    busWrite(3'd0, 0, 32'd3);
    repeat (4) @(negedge clk);
    busWrite(3'd0, 0, 32'd1);
    repeat (10) @(negedge clk);
    check(32'(stOf(0)), 32'd0, "R7 old request dropped");
    @(negedge clk);
    check(32'(stOf(0)), 32'd2, "R7 new request applied");

    // capture setup: domain 2 on; ON domains are d1, d2
    busWrite(3'd0, 2, 32'd3);
    @(negedge clk);
    check(32'(stOf(2)), 32'd1, "R9 d2 on");

    // R9 capture
    busWrite(3'd2, 0, 32'd1);
    repeat (9) @(negedge clk);
    busWrite(3'd2, 0, 32'd0);
    busRead(3'd2, 0, 32'd20, "R9 capture 10 edges x2");
    repeat (7) @(negedge clk);
    busRead(3'd2, 0, 32'd20, "R9 holds after stop");
    busWrite(3'd2, 0, 32'd1);
    busWrite(3'd2, 0, 32'd0);
    busRead(3'd2, 0, 32'd2, "R9 restart clears");

    // R10 saturation on narrow copy
    busWrite(3'd2, 0, 32'd1);
    repeat (40) @(negedge clk);
    busWrite(3'd2, 0, 32'd0);
    busRead(3'd2, 0, 32'd82, "R10 wide count");
    check(satRdData, 32'd63, "R10 narrow count saturates");

    repeat (3) @(negedge clk);
    check(32'(expQ.size()), 32'd0, "R11 all reads answered");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule